// File: doc/BRIEF.md
# Delayed Pulse Coincidence Counter

This block counts coincidences between two streams of detector pulses, where one stream is compared against a delayed copy of itself. Both inputs are single-bit pulses that arrive at any phase relative to the clock. Each input is brought into the clock domain and turned into a one-cycle event strobe per rising edge. Every event on channel A is replayed exactly `DELAY_CYCLES` clock cycles later. The replay is then tested against the channel B events. If the two fall within `WINDOW` cycles of each other, one coincidence is recorded.

The long delay (for example 100,000 cycles, one source repetition period at 50 MHz) is not built from a line of sampled bits. Instead, each channel A event stores the due time of its replay into a small FIFO. A free-running timestamp counter fires the replay when it reaches the value at the head of that FIFO. Equality modulo 2^`TS_W` keeps the delay exact across counter wrap-around. Time resolution is one clock period.

Saturating counters keep totals of:
- raw A events,
- raw B events,
- coincidences,
- A events dropped because the FIFO was full.

A synchronous clear input zeroes all four counters without disturbing replays that are still pending.

Top module: `pulse_coinc_top`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block is reset. After that edge, all four counters read zero and `a_dly_o` and `coinc_o` are low.
- R2: Each rising edge on an input adds exactly one event to that channel's counter. This holds for a pulse high for a single clock and for a level held high for many clocks.
- R3: Let edge k be the first clock edge that samples `a_in` high. Then `a_dly_o` is high for exactly one cycle, beginning at edge k+1+`DELAY_CYCLES`.
- R4: Let channel A first be sampled high at edge k, and channel B first be sampled high at edge j. If |j − (k+`DELAY_CYCLES`)| ≤ `WINDOW`, then `cnt_coinc` increases by one and `coinc_o` pulses once.
- R5: A B event that falls more than `WINDOW` cycles from every delayed A event adds nothing to `cnt_coinc` and produces no `coinc_o` pulse.
- R6: An A event that arrives while `FIFO_DEPTH` replays are already pending has the following effects:
  - it is counted in `cnt_a`;
  - it increments `cnt_drop`;
  - it produces no delayed pulse.
- R7: Each counter is `CNT_W` bits wide. It stops at all ones and does not wrap.
- R8: `clr` high at a clock edge zeroes all four counters at that edge. Replays already pending still appear at their due cycle.
- R9: The delay stays exact when the `TS_W`-bit timestamp counter wraps between an event and its replay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clr | input | 1 | Synchronous clear of all counters |
| a_in | input | 1 | Channel A pulse, asynchronous |
| b_in | input | 1 | Channel B pulse, asynchronous |
| a_dly_o | output | 1 | One-cycle replay of each kept A event |
| coinc_o | output | 1 | One-cycle pulse per coincidence |
| cnt_a | output | CNT_W | Saturating count of A events |
| cnt_b | output | CNT_W | Saturating count of B events |
| cnt_coinc | output | CNT_W | Saturating count of coincidences |
| cnt_drop | output | CNT_W | Saturating count of dropped A events |

## Verification
The bench places B pulses at offsets of −2 to +2 cycles around each replay of A, with a window of one. A design with an off-by-one in the replay latency or the window edges would count the ±2 cases or miss the ±1 cases.

A burst of six closely spaced A pulses, sent into a four-deep FIFO, checks the following:
- a design that overwrote the head would replay the wrong times;
- a design that lost the drop count would show zero drops.

A long run of A pulses crosses several wraps of an 8-bit timestamp, where a magnitude compare would miss or fire early. A clear issued while a replay is pending, and 300 B pulses against an 8-bit counter, expose these faults:
- a clear that flushes the FIFO;
- a counter that wraps instead of holding.

// File: rtl/coinc_pkg.sv
// Package: shared helpers for the delayed pulse coincidence counter.
// Assumes: nothing beyond IEEE 1800-2017 constant functions.
package coinc_pkg;

    // Width of an index into n entries, never less than one bit.
    function automatic int unsigned idx_width(int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    // Width able to hold the value n itself.
    function automatic int unsigned level_width(int unsigned n);
        return $clog2(n + 1);
    endfunction

endpackage

// File: rtl/coinc_edge_sync.sv
// Module: coinc_edge_sync
// Brings one asynchronous pulse line into the clock domain through two
// flops, then emits a single-cycle strobe for each rising edge seen.
// Assumes: input stays high for at least one sampling edge per pulse.
module coinc_edge_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic stb
);
    logic [2:0] stage;

    // Purpose: shift the input through the synchronizer and one history flop.
    always_ff @(posedge clk) begin
        if (!rst_n) stage <= '0;
        else        stage <= {stage[1:0], din};
    end

    // Purpose: rising edge on the synchronized level.
    always_comb stb = stage[1] & ~stage[2];

    assert_single_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        stb |=> !stb);

    assert_level_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
        stb |=> stage[2]);

endmodule

// File: rtl/coinc_ts_fifo.sv
// Module: coinc_ts_fifo
// Small circular FIFO of replay timestamps. One write and one read per cycle.
// Assumes: caller never pushes when full nor pops when empty.
module coinc_ts_fifo #(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned W     = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         empty,
    output logic         full
);
    import coinc_pkg::*;

    localparam int unsigned AW = idx_width(DEPTH);
    localparam int unsigned LW = level_width(DEPTH);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
    localparam logic [LW-1:0] FULL_LVL = LW'(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wptr, rptr;
    logic [LW-1:0] level;

    // Purpose: store an incoming timestamp.
    always_ff @(posedge clk) begin
        if (push) mem[wptr] <= wdata;
    end

    // Purpose: advance pointers and track occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            level <= '0;
        end else begin
            if (push) wptr <= (wptr == LAST) ? '0 : wptr + 1'b1;
            if (pop)  rptr <= (rptr == LAST) ? '0 : rptr + 1'b1;
            case ({push, pop})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end

    // Purpose: expose head and status.
    always_comb begin
        head  = mem[rptr];
        empty = (level == '0);
        full  = (level == FULL_LVL);
    end

    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(push && full));

    assert_no_underflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(pop && empty));

    assert_level_grows_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop) |=> level == $past(level) + 1'b1);

endmodule

// File: rtl/coinc_sat_counter.sv
// Module: coinc_sat_counter
// Event counter that holds at all ones and clears synchronously.
// Assumes: at most one increment per cycle.
module coinc_sat_counter #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] q
);
    localparam logic [W-1:0] TOP = '1;

    // Purpose: count, saturate, clear.
    always_ff @(posedge clk) begin
        if (!rst_n)                 q <= '0;
        else if (clr)               q <= '0;
        else if (inc && q != TOP)   q <= q + 1'b1;
    end

    assert_hold_at_top_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && q == TOP) |=> q == TOP);

    assert_step_one_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && inc && q != TOP) |=> q == $past(q) + 1'b1);

    assert_clear_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> q == '0);

endmodule

// File: rtl/pulse_coinc_top.sv
// Module: pulse_coinc_top
// Synchronizes two pulse channels. Channel A events are replayed exactly
// DELAY_CYCLES later through a FIFO of due times compared with a
// free-running timestamp. Coincidences between the replay and channel B
// within +/-WINDOW cycles are counted.
// Assumes: 3 <= DELAY_CYCLES < 2**TS_W, WINDOW much smaller than DELAY_CYCLES.
module pulse_coinc_top #(
    parameter int unsigned DELAY_CYCLES = 100000,
    parameter int unsigned FIFO_DEPTH   = 16,
    parameter int unsigned WINDOW       = 0,
    parameter int unsigned TS_W         = 32,
    parameter int unsigned CNT_W        = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             a_in,
    input  logic             b_in,
    output logic             a_dly_o,
    output logic             coinc_o,
    output logic [CNT_W-1:0] cnt_a,
    output logic [CNT_W-1:0] cnt_b,
    output logic [CNT_W-1:0] cnt_coinc,
    output logic [CNT_W-1:0] cnt_drop
);
    // Replay is registered, so the due time is stored one cycle early.
    localparam logic [TS_W-1:0] DUE_OFS = TS_W'(DELAY_CYCLES - 1);

    logic            a_stb, b_stb;
    logic [TS_W-1:0] ts;
    logic [TS_W-1:0] head;
    logic            f_empty, f_full;
    logic            push_a, drop_a, due;
    logic            a_dly_q, late_a, b_win, hit, coinc_q;

    initial begin
        assert (DELAY_CYCLES >= 3) else $error("DELAY_CYCLES must be at least 3");
    end

    coinc_edge_sync u_sync_a (.clk(clk), .rst_n(rst_n), .din(a_in), .stb(a_stb));
    coinc_edge_sync u_sync_b (.clk(clk), .rst_n(rst_n), .din(b_in), .stb(b_stb));

    // Purpose: free-running timestamp, wraps modulo 2**TS_W.
    always_ff @(posedge clk) begin
        if (!rst_n) ts <= '0;
        else        ts <= ts + 1'b1;
    end

    // Purpose: decide push, drop and replay for the current cycle.
    always_comb begin
        push_a = a_stb & ~f_full;
        drop_a = a_stb &  f_full;
        due    = ~f_empty & (head == ts);
    end

    coinc_ts_fifo #(.DEPTH(FIFO_DEPTH), .W(TS_W)) u_fifo (
        .clk  (clk),
        .rst_n(rst_n),
        .push (push_a),
        .wdata(ts + DUE_OFS),
        .pop  (due),
        .head (head),
        .empty(f_empty),
        .full (f_full)
    );

    // Purpose: register the replay pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) a_dly_q <= 1'b0;
        else        a_dly_q <= due;
    end

    // Window alignment: delay the replay by WINDOW and keep 2*WINDOW of B history.
    generate
        if (WINDOW == 0) begin : g_exact
            always_comb begin
                late_a = a_dly_q;
                b_win  = b_stb;
            end
        end else begin : g_window
            logic [WINDOW-1:0]   a_pipe;
            logic [2*WINDOW-1:0] b_hist;

            // Purpose: shift replay and B strobes through their alignment lines.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    a_pipe <= '0;
                    b_hist <= '0;
                end else begin
                    a_pipe[0] <= a_dly_q;
                    b_hist[0] <= b_stb;
                    for (int i = 1; i < WINDOW; i++)     a_pipe[i] <= a_pipe[i-1];
                    for (int i = 1; i < 2 * WINDOW; i++) b_hist[i] <= b_hist[i-1];
                end
            end

            always_comb begin
                late_a = a_pipe[WINDOW-1];
                b_win  = b_stb | (|b_hist);
            end
        end
    endgenerate

    // Purpose: coincidence decision and its output pulse.
    always_comb hit = late_a & b_win;

    always_ff @(posedge clk) begin
        if (!rst_n) coinc_q <= 1'b0;
        else        coinc_q <= hit;
    end

    coinc_sat_counter #(.W(CNT_W)) u_cnt_a (
        .clk(clk), .rst_n(rst_n), .clr(clr), .inc(a_stb), .q(cnt_a));
    coinc_sat_counter #(.W(CNT_W)) u_cnt_b (
        .clk(clk), .rst_n(rst_n), .clr(clr), .inc(b_stb), .q(cnt_b));
    coinc_sat_counter #(.W(CNT_W)) u_cnt_c (
        .clk(clk), .rst_n(rst_n), .clr(clr), .inc(hit), .q(cnt_coinc));
    coinc_sat_counter #(.W(CNT_W)) u_cnt_d (
        .clk(clk), .rst_n(rst_n), .clr(clr), .inc(drop_a), .q(cnt_drop));

    always_comb begin
        a_dly_o = a_dly_q;
        coinc_o = coinc_q;
    end

    assert_replay_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        a_dly_o |=> !a_dly_o);

    assert_kept_is_pending_R6: assert property (@(posedge clk) disable iff (!rst_n)
        push_a |=> !f_empty);

    assert_coinc_needs_late_R4: assert property (@(posedge clk) disable iff (!rst_n)
        coinc_o |-> $past(late_a) && $past(b_win));

    assert_clear_keeps_pending_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !f_empty && !due) |=> !f_empty);

endmodule

// File: tb/pulse_coinc_top_tb.sv
module pulse_coinc_top_tb;
    localparam int unsigned D  = 40;
    localparam int unsigned FD = 4;
    localparam int unsigned WN = 1;
    localparam int unsigned TW = 8;
    localparam int unsigned CW = 8;
    localparam int CMAX = (1 << CW) - 1;

    logic clk = 1'b0, rst_n = 1'b0, clr = 1'b0, a_in = 1'b0, b_in = 1'b0;
    logic a_dly_o, coinc_o;
    logic [CW-1:0] cnt_a, cnt_b, cnt_coinc, cnt_drop;

    int total = 0, bad = 0, cyc = 0;
    int ea = 0, eb = 0, ec = 0, ed = 0, tot_coinc = 0, seen_coinc = 0;
    int exp_q[$];
    bit done = 0;

    pulse_coinc_top #(.DELAY_CYCLES(D), .FIFO_DEPTH(FD), .WINDOW(WN),
                      .TS_W(TW), .CNT_W(CW)) u_dut (
        .clk(clk), .rst_n(rst_n), .clr(clr), .a_in(a_in), .b_in(b_in),
        .a_dly_o(a_dly_o), .coinc_o(coinc_o), .cnt_a(cnt_a), .cnt_b(cnt_b),
        .cnt_coinc(cnt_coinc), .cnt_drop(cnt_drop));

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(string req, int got, int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    function automatic int sat(int v);
        return (v > CMAX) ? CMAX : v;
    endfunction

    task automatic check_counts(string tag);
        check({tag, " R2 cnt_a"},    int'(cnt_a),     sat(ea));
        check({tag, " R2 cnt_b"},    int'(cnt_b),     sat(eb));
        check({tag, " R4 cnt_coinc"}, int'(cnt_coinc), sat(ec));
        check({tag, " R6 cnt_drop"}, int'(cnt_drop),  sat(ed));
    endtask

    // Driver: one-cycle A pulse; queues the expected replay cycle when kept.
    task automatic drive_a(input bit keep, output int k);
        @(negedge clk);
        k = cyc + 1;
        if (keep) exp_q.push_back(k + 1 + D);
        a_in = 1'b1;
        @(negedge clk);
        a_in = 1'b0;
        ea++;
        if (!keep) ed++;
    endtask

    task automatic wait_until(int t);
        while (cyc < t) @(negedge clk);
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    // Monitor: pop the scoreboard on every replay and compare its cycle (R3).
    always @(negedge clk) begin
        if (rst_n && a_dly_o) begin
            if (exp_q.size() == 0) check("R3 unexpected replay", cyc, -1);
            else                   check("R3 replay cycle", cyc, exp_q.pop_front());
        end
        if (rst_n && coinc_o) seen_coinc++;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int k;
        idle(5);
        // R1: reset state
        check("R1 a_dly_o", int'(a_dly_o), 0);
        check("R1 coinc_o", int'(coinc_o), 0);
        check_counts("R1");
        rst_n = 1'b1;
        idle(3);

        // R3: single A pulse replayed after exactly D cycles
        drive_a(1'b1, k);
        idle(D + 8);
        check_counts("R3 single");

        // R2: long level counts once
        @(negedge clk);
        k = cyc + 1;
        exp_q.push_back(k + 1 + D);
        a_in = 1'b1;
        idle(20);
        a_in = 1'b0;
        ea++;
        idle(D + 8);
        check_counts("R2 held");

        // R4 / R5: B at offsets -2..+2 around the replay
        for (int off = -2; off <= 2; off++) begin
            drive_a(1'b1, k);
            wait_until(k + D + off - 1);
            b_in = 1'b1;
            @(negedge clk);
            b_in = 1'b0;
            eb++;
            if (off >= -int'(WN) && off <= int'(WN)) begin
                ec++; tot_coinc++;
            end
            idle(D + 8);
            check_counts((off >= -1 && off <= 1) ? "R4 in window" : "R5 outside");
        end

        // R6: burst beyond FIFO depth
        for (int i = 0; i < FD + 2; i++) drive_a(i < FD, k);
        idle(D + 12);
        check_counts("R6 burst");
        check("R6 pending empty", exp_q.size(), 0);

        // R9: spaced events across several timestamp wraps
        for (int i = 0; i < 10; i++) begin
            drive_a(1'b1, k);
            idle(35);
        end
        idle(D + 8);
        check_counts("R9 wrap");
        check("R9 pending empty", exp_q.size(), 0);

        // R8: clear while a replay is pending
        drive_a(1'b1, k);
        idle(5);
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        ea = 0; eb = 0; ec = 0; ed = 0;
        check_counts("R8 clear");
        idle(D + 8);
        check("R8 pending replay delivered", exp_q.size(), 0);

        // R7: saturation of the B counter
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            b_in = 1'b1;
            @(negedge clk);
            b_in = 1'b0;
            eb++;
        end
        idle(6);
        check("R7 cnt_b saturates", int'(cnt_b), CMAX);
        check_counts("R7");

        check("R4 coinc_o pulses", seen_coinc, tot_coinc);
        check("R3 scoreboard drained", exp_q.size(), 0);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule